// File: doc/BRIEF.md
# Marker-Bit Pad and Unpad Unit

This block moves bit strings of varying length across a bus of fixed width so that the receiver can always tell how long each string was. The pad side takes a payload of up to `W` bits and a length. It returns a word of `W+1` bits. In that word a single `1` marker sits one place above the payload's top bit, and every bit above the marker is `0`. A payload that fills all `W` bits, or one that is entirely zero, therefore stays distinguishable from the fill.

The unpad side takes such a word and finds the highest `1` bit with a priority encoder. The encoder settles within one clock cycle. The marker's position is the payload length, and the bits below the marker are the payload. A word with no `1` bit at all is reported as an error with length 0.

Each side ends in one registered valid/ready stage. The two sides are independent and can be chained. The encoder has two structures, chosen by a parameter: a flat scan, or a two-level scan over segments of `CHUNK` bits.

Top module: `marker_pad_unit`

## Requirements
- R1: The pad word carries a single `1` marker at bit position equal to the payload length, with the payload's bits `[len-1:0]` copied into word bits `[len-1:0]`.
- R2: Every pad word bit above the marker position is `0`.
- R3: Payload input bits at positions equal to or greater than the given length are ignored and appear as `0` in the pad word.
- R4: A pad length input greater than `W` is treated as exactly `W`.
- R5: A full-width payload (length `W`) places the marker at bit `W`, the top bit of the `W+1` bit word, for any payload value including all zeros.
- R6: The unpad length equals the index of the highest `1` bit of the word. The unpad data holds the word bits below that index, and all data bits at or above the length are `0`.
- R7: A word with no `1` bit sets the error output to 1, with length 0 and data 0. Otherwise the error output is 0.
- R8: Unpadding a padded word returns the original masked payload and its length, for `W` = 8 and `W` = 512.
- R9: Each side presents its result one clock after the input handshake. While its output is valid and not accepted, the result holds unchanged.
- R10: During reset, both output valids are 0 and both input readies are 1.
- R11: An input ready is 0 exactly when its side holds a valid output that is not being accepted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_valid | input | 1 | Pad side: payload offered |
| pin_ready | output | 1 | Pad side: payload accepted this cycle |
| pin_data | input | W | Pad side: payload bits, LSB aligned |
| pin_len | input | LW = clog2(W+1) | Pad side: payload length in bits |
| pout_valid | output | 1 | Pad side: padded word available |
| pout_ready | input | 1 | Pad side: downstream accepts padded word |
| pout_word | output | W+1 | Pad side: padded word |
| uin_valid | input | 1 | Unpad side: word offered |
| uin_ready | output | 1 | Unpad side: word accepted this cycle |
| uin_word | input | W+1 | Unpad side: padded word |
| uout_valid | output | 1 | Unpad side: result available |
| uout_ready | input | 1 | Unpad side: downstream accepts result |
| uout_data | output | W | Unpad side: recovered payload |
| uout_len | output | LW | Unpad side: recovered length, 0 to W |
| uout_err | output | 1 | Unpad side: no marker found |

## Verification
The hardest case to reach is the widest one. At `W` = 512 the marker must travel through the top segment of the encoder, which is partly empty, and must come back out of the unpad stage intact. The bench drives a second instance at that width with its pad output wired straight into its unpad input. It pushes full-width, odd-length, 511-bit and empty payloads through that instance, so the encoder's segment boundaries and the padded tail segment are both exercised. The backpressure hold is reached by lowering the output ready while a new payload is still offered. This shows that the held word does not change.

// File: rtl/mp_pkg.sv
package mp_pkg;
   // leading-one encoder structures
   localparam int MP_ENC_FLAT = 0;
   localparam int MP_ENC_SEG  = 1;

   // width of a field that counts 0..n
   function automatic int mp_cnt_w(input int n);
      return (n > 1) ? $clog2(n + 1) : 1;
   endfunction
endpackage

// File: rtl/mp_pipe_reg.sv
module mp_pipe_reg #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);
   logic          v_q;
   logic [DW-1:0] d_q;

   assign in_ready  = !v_q || out_ready;
   assign out_valid = v_q;
   assign out_data  = d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         d_q <= '0;
      end else if (in_ready) begin
         v_q <= in_valid;
         if (in_valid) d_q <= in_data;
      end
   end
endmodule

// File: rtl/mp_lead_one.sv
module mp_lead_one
   import mp_pkg::*;
#(
   parameter int N     = 9,
   parameter int STYLE = MP_ENC_SEG,
   parameter int CHUNK = 8,
   localparam int PW   = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  vec,
   output logic          found,
   output logic [PW-1:0] pos
);
   if (STYLE == MP_ENC_FLAT) begin : g_flat
      // single scan, last hit from the bottom wins
      always_comb begin
         found = 1'b0;
         pos   = '0;
         for (int i = 0; i < N; i++) begin
            if (vec[i]) begin
               found = 1'b1;
               pos   = PW'(i);
            end
         end
      end
   end else begin : g_seg
      localparam int NSEG = (N + CHUNK - 1) / CHUNK;
      localparam int NP   = NSEG * CHUNK;
      localparam int SW   = (NSEG > 1) ? $clog2(NSEG) : 1;
      localparam int CW   = (CHUNK > 1) ? $clog2(CHUNK) : 1;

      logic [NP-1:0]    ext;
      logic [NSEG-1:0]  seg_any;
      logic [SW-1:0]    seg_sel;
      logic [CHUNK-1:0] seg_bits;
      logic [CW-1:0]    off;

      assign ext = NP'(vec);

      for (genvar s = 0; s < NSEG; s++) begin : g_any
         assign seg_any[s] = |ext[s*CHUNK +: CHUNK];
      end

      always_comb begin
         seg_sel = '0;
         for (int s = 0; s < NSEG; s++) begin
            if (seg_any[s]) seg_sel = SW'(s);
         end
      end

      assign seg_bits = ext[int'(seg_sel)*CHUNK +: CHUNK];

      always_comb begin
         off = '0;
         for (int b = 0; b < CHUNK; b++) begin
            if (seg_bits[b]) off = CW'(b);
         end
      end

      assign found = |seg_any;
      assign pos   = PW'(int'(seg_sel) * CHUNK + int'(off));
   end
endmodule

// File: rtl/mp_pad_core.sv
module mp_pad_core #(
   parameter int W  = 8,
   parameter int LW = 4
) (
   input  logic [W-1:0]  data,
   input  logic [LW-1:0] len,
   output logic [W:0]    word
);
   logic [LW-1:0] len_s;

   // lengths beyond the bus saturate at full width
   assign len_s = (int'(len) > W) ? LW'(W) : len;

   always_comb begin
      word = '0;
      for (int i = 0; i < W; i++) begin
         if (i < int'(len_s)) word[i] = data[i];
      end
      for (int i = 0; i <= W; i++) begin
         if (i == int'(len_s)) word[i] = 1'b1;
      end
   end
endmodule

// File: rtl/mp_unpad_core.sv
module mp_unpad_core
   import mp_pkg::*;
#(
   parameter int W     = 8,
   parameter int LW    = 4,
   parameter int STYLE = MP_ENC_SEG,
   parameter int CHUNK = 8
) (
   input  logic [W:0]    word,
   output logic [W-1:0]  data,
   output logic [LW-1:0] len,
   output logic          err
);
   logic          hit;
   logic [LW-1:0] mark;

   mp_lead_one #(.N(W + 1), .STYLE(STYLE), .CHUNK(CHUNK)) u_lead (
      .vec   (word),
      .found (hit),
      .pos   (mark)
   );

   assign err = !hit;
   assign len = hit ? mark : '0;

   always_comb begin
      data = '0;
      for (int i = 0; i < W; i++) begin
         if (i < int'(len)) data[i] = word[i];
      end
   end
endmodule

// File: rtl/marker_pad_unit.sv
module marker_pad_unit
   import mp_pkg::*;
#(
   parameter int W         = 8,
   parameter int ENC_STYLE = MP_ENC_SEG,
   parameter int CHUNK     = 8,
   localparam int LW       = $clog2(W + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pin_valid,
   output logic          pin_ready,
   input  logic [W-1:0]  pin_data,
   input  logic [LW-1:0] pin_len,
   output logic          pout_valid,
   input  logic          pout_ready,
   output logic [W:0]    pout_word,
   input  logic          uin_valid,
   output logic          uin_ready,
   input  logic [W:0]    uin_word,
   output logic          uout_valid,
   input  logic          uout_ready,
   output logic [W-1:0]  uout_data,
   output logic [LW-1:0] uout_len,
   output logic          uout_err
);
   localparam int UDW = W + LW + 1;

   // elaboration checks
   if (W < 1) begin : g_bad_w
      $error("marker_pad_unit: W must be at least 1");
   end
   if (CHUNK < 1) begin : g_bad_chunk
      $error("marker_pad_unit: CHUNK must be at least 1");
   end
   if (ENC_STYLE != MP_ENC_FLAT && ENC_STYLE != MP_ENC_SEG) begin : g_bad_style
      $error("marker_pad_unit: unknown ENC_STYLE");
   end

   // pad side
   logic [W:0] pad_w;

   mp_pad_core #(.W(W), .LW(LW)) u_pad (
      .data (pin_data),
      .len  (pin_len),
      .word (pad_w)
   );

   mp_pipe_reg #(.DW(W + 1)) u_pad_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (pin_valid),
      .in_ready  (pin_ready),
      .in_data   (pad_w),
      .out_valid (pout_valid),
      .out_ready (pout_ready),
      .out_data  (pout_word)
   );

   // unpad side
   logic [W-1:0]  un_d;
   logic [LW-1:0] un_l;
   logic          un_e;
   logic [UDW-1:0] un_q;

   mp_unpad_core #(.W(W), .LW(LW), .STYLE(ENC_STYLE), .CHUNK(CHUNK)) u_unpad (
      .word (uin_word),
      .data (un_d),
      .len  (un_l),
      .err  (un_e)
   );

   mp_pipe_reg #(.DW(UDW)) u_unpad_reg (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (uin_valid),
      .in_ready  (uin_ready),
      .in_data   ({un_e, un_l, un_d}),
      .out_valid (uout_valid),
      .out_ready (uout_ready),
      .out_data  (un_q)
   );

   assign {uout_err, uout_len, uout_data} = un_q;
endmodule

// File: rtl/mp_checker.sv
module mp_checker #(
   parameter int W  = 8,
   parameter int LW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          pin_ready,
   input logic          pout_valid,
   input logic          pout_ready,
   input logic [W:0]    pout_word,
   input logic          uout_valid,
   input logic          uout_ready,
   input logic [W-1:0]  uout_data,
   input logic [LW-1:0] uout_len,
   input logic          uout_err
);
   AST_PAD_MARKER: assert property (@(posedge clk) disable iff (!rst_n)
      pout_valid |-> (pout_word != '0)); // R1

   AST_PAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pout_valid && !pout_ready |=> pout_valid && $stable(pout_word)); // R9

   AST_UNPAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      uout_valid && !uout_ready |=> uout_valid && $stable({uout_err, uout_len, uout_data})); // R9

   AST_ERR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      uout_valid && uout_err |-> (uout_len == '0) && (uout_data == '0)); // R7

   AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      uout_valid |-> (int'(uout_len) <= W)); // R6

   AST_DATA_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      uout_valid |-> ((uout_data >> uout_len) == '0)); // R6

   AST_PAD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      pout_valid && !pout_ready |-> !pin_ready); // R11
endmodule

bind marker_pad_unit mp_checker #(.W(W), .LW(LW)) u_chk (.*);

// File: tb/sim_marker_pad_unit.sv
module sim_marker_pad_unit;
   localparam int CLK_PERIOD = 10;
   localparam int W0 = 8;
   localparam int L0 = 4;
   localparam int W1 = 512;
   localparam int L1 = 10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // narrow instance, both sides driven separately
   logic          pin_valid0 = 0, pin_ready0, pout_valid0, pout_ready0 = 1;
   logic [W0-1:0] pin_data0 = '0;
   logic [L0-1:0] pin_len0 = '0;
   logic [W0:0]   pout_word0;
   logic          uin_valid0 = 0, uin_ready0, uout_valid0, uout_ready0 = 1, uout_err0;
   logic [W0:0]   uin_word0 = '0;
   logic [W0-1:0] uout_data0;
   logic [L0-1:0] uout_len0;

   marker_pad_unit #(.W(W0)) u0 (
      .clk(clk), .rst_n(rst_n),
      .pin_valid(pin_valid0), .pin_ready(pin_ready0), .pin_data(pin_data0), .pin_len(pin_len0),
      .pout_valid(pout_valid0), .pout_ready(pout_ready0), .pout_word(pout_word0),
      .uin_valid(uin_valid0), .uin_ready(uin_ready0), .uin_word(uin_word0),
      .uout_valid(uout_valid0), .uout_ready(uout_ready0), .uout_data(uout_data0),
      .uout_len(uout_len0), .uout_err(uout_err0)
   );

   // wide instance, pad output chained into unpad input
   logic          pin_valid1 = 0, pin_ready1, pout_valid1, uin_ready1, uout_valid1, uout_err1;
   logic [W1-1:0] pin_data1 = '0;
   logic [L1-1:0] pin_len1 = '0;
   logic [W1:0]   pout_word1;
   logic [W1-1:0] uout_data1;
   logic [L1-1:0] uout_len1;

   marker_pad_unit #(.W(W1)) u1 (
      .clk(clk), .rst_n(rst_n),
      .pin_valid(pin_valid1), .pin_ready(pin_ready1), .pin_data(pin_data1), .pin_len(pin_len1),
      .pout_valid(pout_valid1), .pout_ready(uin_ready1), .pout_word(pout_word1),
      .uin_valid(pout_valid1), .uin_ready(uin_ready1), .uin_word(pout_word1),
      .uout_valid(uout_valid1), .uout_ready(1'b1), .uout_data(uout_data1),
      .uout_len(uout_len1), .uout_err(uout_err1)
   );

   typedef struct packed {
      logic [7:0] d;
      logic [3:0] l;
      logic [8:0] w;
      logic [7:0] ud;
      logic [3:0] ul;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{8'h15, 4'd5,  9'h035, 8'h15, 4'd5},  // R1 mid length
      '{8'h00, 4'd8,  9'h100, 8'h00, 4'd8},  // R5 all-zero full width
      '{8'hFF, 4'd8,  9'h1FF, 8'hFF, 4'd8},  // R5 all-one full width
      '{8'hFF, 4'd3,  9'h00F, 8'h07, 4'd3},  // R3 upper bits dropped
      '{8'hAB, 4'd0,  9'h001, 8'h00, 4'd0},  // R3 empty payload
      '{8'h5A, 4'd12, 9'h15A, 8'h5A, 4'd8},  // R4 length saturates
      '{8'h80, 4'd7,  9'h080, 8'h00, 4'd7},  // R2 top bit above marker zero
      '{8'h01, 4'd1,  9'h003, 8'h01, 4'd1}   // R1 shortest
   };

   task automatic chk(input bit ok, input string tag,
                      input logic [531:0] act, input logic [531:0] exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic wide_trip(input logic [W1-1:0] d, input int len);
      logic [W1-1:0] m;
      for (int i = 0; i < W1; i++) m[i] = (i < len) ? d[i] : 1'b0;
      @(negedge clk);
      pin_valid1 = 1'b1;
      pin_data1  = d;
      pin_len1   = L1'(len);
      @(negedge clk);
      pin_valid1 = 1'b0;
      chk(pout_valid1 && pout_word1[len] && ((pout_word1 >> (len + 1)) == '0),
          "R1 R2 R5 wide pad marker", pout_word1, {1'b1, m});
      @(negedge clk);
      chk(uout_valid1 && !uout_err1 && int'(uout_len1) == len && uout_data1 == m,
          "R8 wide round trip", {uout_err1, uout_len1, uout_data1}, {1'b0, L1'(len), m});
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog all requirements act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      // R10 reset state
      repeat (3) @(negedge clk);
      chk(!pout_valid0 && !uout_valid0 && pin_ready0 && uin_ready0 && !pout_valid1 && !uout_valid1,
          "R10 reset state", {pout_valid0, uout_valid0, pin_ready0, uin_ready0}, 4'b0011);
      rst_n = 1'b1;

      // table walk: pad and unpad of each vector (R1..R6, R8)
      for (int k = 0; k < NV; k++) begin
         @(negedge clk);
         pin_valid0 = 1'b1;  pin_data0 = VECS[k].d;  pin_len0 = VECS[k].l;
         uin_valid0 = 1'b1;  uin_word0 = VECS[k].w;
         @(negedge clk);
         pin_valid0 = 1'b0;  uin_valid0 = 1'b0;
         chk(pout_valid0 && pout_word0 == VECS[k].w,
             $sformatf("R1 R2 R9 pad word row %0d", k), pout_word0, VECS[k].w);
         chk(uout_valid0 && !uout_err0 && uout_data0 == VECS[k].ud && uout_len0 == VECS[k].ul,
             $sformatf("R6 R8 unpad row %0d", k), {uout_err0, uout_len0, uout_data0},
             {1'b0, VECS[k].ul, VECS[k].ud});
      end

      // R7 no marker
      @(negedge clk);
      uin_valid0 = 1'b1;  uin_word0 = '0;
      @(negedge clk);
      uin_valid0 = 1'b0;
      chk(uout_valid0 && uout_err0 && uout_len0 == 0 && uout_data0 == 0,
          "R7 empty word", {uout_err0, uout_len0, uout_data0}, 13'h1000);

      // R6 arbitrary word, highest one at bit 7
      @(negedge clk);
      uin_valid0 = 1'b1;  uin_word0 = 9'h0B5;
      @(negedge clk);
      uin_valid0 = 1'b0;
      chk(uout_valid0 && !uout_err0 && uout_len0 == 7 && uout_data0 == 8'h35,
          "R6 leading one", {uout_err0, uout_len0, uout_data0}, {1'b0, 4'd7, 8'h35});

      // R9 R11 backpressure on pad side
      @(negedge clk);
      pout_ready0 = 1'b0;
      pin_valid0 = 1'b1;  pin_data0 = 8'h15;  pin_len0 = 4'd5;
      @(negedge clk);
      chk(pout_valid0 && !pin_ready0, "R11 stall ready", {pout_valid0, pin_ready0}, 2'b10);
      pin_data0 = 8'hFF;  pin_len0 = 4'd8;
      @(negedge clk);
      chk(pout_valid0 && pout_word0 == 9'h035, "R9 hold under stall", pout_word0, 9'h035);
      pin_valid0 = 1'b0;  pout_ready0 = 1'b1;
      @(negedge clk);
      chk(!pout_valid0 && pin_ready0, "R11 drain", {pout_valid0, pin_ready0}, 2'b01);

      // R8 wide instance
      wide_trip({16{32'hDEADBEEF}}, 512);
      wide_trip({16{32'h0F1E2D3C}}, 100);
      wide_trip('0, 512);
      wide_trip({W1{1'b1}}, 511);
      wide_trip({16{32'h12345678}}, 0);
      wide_trip({16{32'hA5A5A5A5}}, 9);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule